// File: doc/BRIEF.md
# Descriptor-Table Bus-Master DMA Engine

This block moves sector data for a disk interface between a byte-wide device port and system memory without processor help. Software places a table of scatter-gather descriptors in memory, loads the table's base address, picks a direction and sets the start bit. The engine then reads each descriptor in turn and moves one byte per beat. It moves bytes either from the device into the buffers or from the buffers out to the device, and carries on until either side runs out.

The final status depends on which side runs out first. If the device and the table end on the same byte, the engine completes and raises its interrupt. If the device finishes while buffer space remains, the engine raises the interrupt but stays active, holding idle until software clears the start bit. If the table is used up while the device still has data, the engine stops without raising the interrupt. Clearing the start bit at any time abandons the transfer. A bus error from memory stops the engine and sets the error flag.

Top module: `prd_dma_engine`

## Requirements
- R1: Register offsets: control at 0 (bit 0 start, bit 3 direction), status at 2 (bit 0 active, bit 1 error, bit 2 interrupt), table base at 4 (32 bits, bits 1:0 read as zero). All three read as zero after reset.
- R2: A 0-to-1 write of the start bit sets active and fetches descriptors in order from the table base, advancing 8 bytes per entry. Each entry is a little-endian buffer-address word, then a count word.
- R3: With direction 1, bytes taken from the device input stream are written to ascending buffer addresses. With direction 0, bytes read from ascending buffer addresses are offered on the device output stream.
- R4: Only bits 15:0 of a count word give the byte count, and a value of zero means 65536 bytes. Bit 31 marks the last entry of the table.
- R5: When the device's final byte also fills the last byte of the last entry, status ends with active 0 and interrupt 1.
- R6: When the device's final byte leaves buffer space unused, status ends with active 1 and interrupt 1, and no further bytes are moved.
- R7: When the last entry fills before the device's final byte, status ends with active 0 and interrupt 0, and no further bytes are moved.
- R8: Writing 0 to the start bit while active clears active at once, and no memory or device beat follows. The interrupt bit keeps its value.
- R9: The irq output equals the interrupt status bit. Writing 1 to status bit 2 clears the interrupt and writing 1 to bit 1 clears the error.
- R10: A memory access answered with a bus error sets the error bit, clears active and stops the engine without an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | 1 for a write beat, 0 for a read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data, byte in bits 7:0 |
| mem_rdata | input | 32 | Little-endian word at mem_addr, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Bus error, qualified by mem_ack |
| din_valid | input | 1 | Device has a byte for memory |
| din_data | input | 8 | Byte from the device |
| din_ready | output | 1 | Engine takes the device byte |
| dout_valid | output | 1 | Engine offers a byte to the device |
| dout_data | output | 8 | Byte to the device |
| dout_ready | input | 1 | Device takes the offered byte |
| dev_final | input | 1 | The byte handshaken this cycle is the device's last |
| irq | output | 1 | Interrupt request |

## Verification
Register writes take effect on the next edge. Status and irq are combinational reads of registers, so the bench samples them half a cycle after a write. Every memory access takes two cycles through the responder, and every byte takes a device handshake plus one memory access. Instead of counting a fixed number of cycles to completion, the bench polls status until it leaves the active-only state. It then waits ten more cycles before judging the status, the number of device bytes moved and the buffer contents, so that a stray extra beat would show. Abort and interrupt clearing act on the edge of the register write, and the bench reads status immediately after that write.

// File: rtl/prd_dma_pkg.sv
package prd_dma_pkg;

    localparam logic [2:0] OFS_CTRL = 3'd0;
    localparam logic [2:0] OFS_STAT = 3'd2;
    localparam logic [2:0] OFS_BASE = 3'd4;

    localparam int CTRL_RUN   = 0;
    localparam int CTRL_TOMEM = 3;
    localparam int STAT_ACT   = 0;
    localparam int STAT_ERR   = 1;
    localparam int STAT_IRQ   = 2;
    localparam int DESC_TAIL  = 31;

    typedef enum logic [2:0] {
        W_IDLE, W_DESC_A, W_DESC_C, W_DEV_IN,
        W_MEM_WR, W_MEM_RD, W_DEV_OUT, W_HOLD
    } walk_t;

    typedef enum logic [1:0] {
        END_MORE, END_EXACT, END_LONG, END_SHORT
    } end_t;

    typedef struct packed {
        logic clr_active;
        logic set_intr;
        logic set_err;
    } walk_evt_t;

    function automatic end_t classify(logic fin, logic empty, logic tail);
        if (fin && empty && tail) return END_EXACT;
        if (fin)                  return END_LONG;
        if (empty && tail)        return END_SHORT;
        return END_MORE;
    endfunction

endpackage

// File: rtl/prd_dma_regs.sv
module prd_dma_regs
    import prd_dma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [2:0]    addr,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] rdata,
    input  walk_evt_t     evt,
    output logic          go,
    output logic          go_tomem,
    output logic          stop,
    output logic [AW-1:0] tbl_base,
    output logic          irq
);
    logic          run_q, tomem_q, act_q, err_q, intr_q;
    logic [AW-1:0] base_q;
    logic          wr_ctrl, wr_stat, wr_base;

    assign wr_ctrl  = we && (addr == OFS_CTRL);
    assign wr_stat  = we && (addr == OFS_STAT);
    assign wr_base  = we && (addr == OFS_BASE);
    assign go       = wr_ctrl && wdata[CTRL_RUN] && !run_q;
    assign stop     = wr_ctrl && !wdata[CTRL_RUN] && run_q;
    assign go_tomem = wdata[CTRL_TOMEM];
    assign tbl_base = base_q;
    assign irq      = intr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            tomem_q <= 1'b0;
            act_q   <= 1'b0;
            err_q   <= 1'b0;
            intr_q  <= 1'b0;
            base_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q   <= wdata[CTRL_RUN];
                tomem_q <= wdata[CTRL_TOMEM];
            end
            if (wr_base)
                base_q <= {wdata[AW-1:2], 2'b00};
            if (go)
                act_q <= 1'b1;
            else if (stop || evt.clr_active)
                act_q <= 1'b0;
            err_q  <= (err_q  & ~(wr_stat & wdata[STAT_ERR])) | evt.set_err;
            intr_q <= (intr_q & ~(wr_stat & wdata[STAT_IRQ])) | evt.set_intr;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_CTRL: begin
                rdata[CTRL_RUN]   = run_q;
                rdata[CTRL_TOMEM] = tomem_q;
            end
            OFS_STAT: begin
                rdata[STAT_ACT] = act_q;
                rdata[STAT_ERR] = err_q;
                rdata[STAT_IRQ] = intr_q;
            end
            OFS_BASE: rdata = base_q;
            default:  rdata = '0;
        endcase
    end

    // R10: a bus error leaves error set and active cleared
    a_r10_err_stops: assert property (@(posedge clk) disable iff (rst)
        evt.set_err |=> (err_q && !act_q));

    // R5: exact completion leaves interrupt set and active cleared
    a_r5_exact_end: assert property (@(posedge clk) disable iff (rst)
        (evt.set_intr && evt.clr_active) |=> (intr_q && !act_q));

    // R9: writing 1 to the interrupt bit drops the irq output
    a_r9_irq_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && wdata[STAT_IRQ] && !evt.set_intr) |=> !irq);

endmodule

// File: rtl/prd_dma_walker.sv
module prd_dma_walker
    import prd_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          go_tomem,
    input  logic          stop,
    input  logic [AW-1:0] tbl_base,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic          din_valid,
    input  logic [DW-1:0] din_data,
    output logic          din_ready,
    output logic          dout_valid,
    output logic [DW-1:0] dout_data,
    input  logic          dout_ready,
    input  logic          dev_final,
    output walk_evt_t     evt
);
    localparam logic [AW-1:0] ENTRY_STEP = AW'(8);
    localparam logic [AW-1:0] WORD_STEP  = AW'(4);
    localparam logic [CW:0]   SPAN_FULL  = {1'b1, {CW{1'b0}}};
    localparam logic [CW:0]   SPAN_ONE   = (CW+1)'(1);

    walk_t         st;
    logic          tomem, tail, final_q;
    logic [AW-1:0] tptr, baddr;
    logic [CW:0]   remain;
    logic [DW-1:0] byte_q;

    logic  beat_done, beat_fin, bus_fault;
    end_t  outcome;
    walk_t data_st;

    assign data_st   = tomem ? W_DEV_IN : W_MEM_RD;
    assign beat_done = (st == W_MEM_WR && mem_ack && !mem_err) ||
                       (st == W_DEV_OUT && dout_ready);
    assign beat_fin  = (st == W_MEM_WR) ? final_q : dev_final;
    assign outcome   = classify(beat_fin, remain == SPAN_ONE, tail);
    assign bus_fault = mem_req && mem_ack && mem_err;

    always_comb begin
        evt = '0;
        if (!stop) begin
            evt.set_err    = bus_fault;
            evt.clr_active = bus_fault ||
                             (beat_done && (outcome == END_EXACT || outcome == END_SHORT));
            evt.set_intr   = beat_done && (outcome == END_EXACT || outcome == END_LONG);
        end
    end

    always_comb begin
        mem_req  = (st == W_DESC_A) || (st == W_DESC_C) ||
                   (st == W_MEM_WR) || (st == W_MEM_RD);
        mem_we   = (st == W_MEM_WR);
        unique case (st)
            W_DESC_A: mem_addr = tptr;
            W_DESC_C: mem_addr = tptr + WORD_STEP;
            default:  mem_addr = baddr;
        endcase
        mem_wdata  = 32'(byte_q);
        din_ready  = (st == W_DEV_IN);
        dout_valid = (st == W_DEV_OUT);
        dout_data  = byte_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= W_IDLE;
            tomem   <= 1'b0;
            tail    <= 1'b0;
            final_q <= 1'b0;
            tptr    <= '0;
            baddr   <= '0;
            remain  <= '0;
            byte_q  <= '0;
        end else if (stop) begin
            st <= W_IDLE;
        end else begin
            if (beat_done) begin
                baddr  <= baddr + AW'(1);
                remain <= remain - SPAN_ONE;
                unique case (outcome)
                    END_EXACT, END_SHORT: st <= W_IDLE;
                    END_LONG:             st <= W_HOLD;
                    default:              st <= (remain == SPAN_ONE) ? W_DESC_A : data_st;
                endcase
            end else if (bus_fault) begin
                st <= W_IDLE;
            end else begin
                unique case (st)
                    W_IDLE: if (go) begin
                        tomem <= go_tomem;
                        tptr  <= tbl_base;
                        st    <= W_DESC_A;
                    end
                    W_DESC_A: if (mem_ack) begin
                        baddr <= mem_rdata[AW-1:0];
                        st    <= W_DESC_C;
                    end
                    W_DESC_C: if (mem_ack) begin
                        remain <= (mem_rdata[CW-1:0] == '0) ? SPAN_FULL
                                                            : {1'b0, mem_rdata[CW-1:0]};
                        tail   <= mem_rdata[DESC_TAIL];
                        tptr   <= tptr + ENTRY_STEP;
                        st     <= data_st;
                    end
                    W_DEV_IN: if (din_valid) begin
                        byte_q  <= din_data;
                        final_q <= dev_final;
                        st      <= W_MEM_WR;
                    end
                    W_MEM_RD: if (mem_ack) begin
                        byte_q <= mem_rdata[DW-1:0];
                        st     <= W_DEV_OUT;
                    end
                    default: st <= st;
                endcase
            end
        end
    end

    // R8: after a stop no memory or device beat is offered
    a_r8_stop_quiet: assert property (@(posedge clk) disable iff (rst)
        stop |=> (!mem_req && !din_ready && !dout_valid));

    // R2: each accepted count word advances the table pointer by one entry
    a_r2_entry_stride: assert property (@(posedge clk) disable iff (rst)
        (st == W_DESC_C && mem_ack && !mem_err && !stop) |=> (tptr == $past(tptr) + ENTRY_STEP));

    // R6: while holding after an early device finish nothing moves
    a_r6_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == W_HOLD) |-> (!mem_req && !din_ready && !dout_valid));

    // R4: a data beat never starts with an empty region
    a_r4_region_nonzero: assert property (@(posedge clk) disable iff (rst)
        (st == W_DEV_IN || st == W_MEM_RD) |-> (remain != '0));

endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine
    import prd_dma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    input  logic        mem_err,
    input  logic        din_valid,
    input  logic [7:0]  din_data,
    output logic        din_ready,
    output logic        dout_valid,
    output logic [7:0]  dout_data,
    input  logic        dout_ready,
    input  logic        dev_final,
    output logic        irq
);
    localparam int AW = 32;
    localparam int CW = 16;
    localparam int DW = 8;

    walk_evt_t     evt;
    logic          go, go_tomem, stop;
    logic [AW-1:0] tbl_base;

    prd_dma_regs #(.AW(AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .evt      (evt),
        .go       (go),
        .go_tomem (go_tomem),
        .stop     (stop),
        .tbl_base (tbl_base),
        .irq      (irq)
    );

    prd_dma_walker #(.AW(AW), .CW(CW), .DW(DW)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .go_tomem   (go_tomem),
        .stop       (stop),
        .tbl_base   (tbl_base),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack),
        .mem_err    (mem_err),
        .din_valid  (din_valid),
        .din_data   (din_data),
        .din_ready  (din_ready),
        .dout_valid (dout_valid),
        .dout_data  (dout_data),
        .dout_ready (dout_ready),
        .dev_final  (dev_final),
        .evt        (evt)
    );

endmodule

// File: tb/sim_prd_dma_engine.sv
module sim_prd_dma_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = 32'd0;
    logic        mem_ack = 1'b0, mem_err = 1'b0;
    logic        din_valid = 1'b0;
    logic [7:0]  din_data = 8'd0;
    logic        din_ready, dout_valid;
    logic [7:0]  dout_data;
    logic        dout_ready = 1'b0, dev_final = 1'b0;
    logic        irq;

    always #4 clk = ~clk;

    prd_dma_engine u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .din_valid(din_valid), .din_data(din_data),
        .din_ready(din_ready), .dout_valid(dout_valid), .dout_data(dout_data),
        .dout_ready(dout_ready), .dev_final(dev_final), .irq(irq)
    );

    int nchk = 0, nerr = 0;
    logic [7:0]  m [0:1023];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    int  dev_n = 0, dev_idx = 0;
    bit  dev_en = 1'b0, hs_pend = 1'b0;
    logic [7:0] cap = 8'd0;
    logic [7:0] rx [0:63];
    int  dlen [0:3];
    logic [31:0] dword [0:3];

    localparam logic [31:0] TBL = 32'h100;

    function automatic logic [7:0] pat(int seed, int k);
        return 8'((seed * 37 + k * 11 + 5) & 255);
    endfunction

    function automatic logic [31:0] buf_of(int j);
        return 32'h200 + 32'(j) * 32'h40;
    endfunction

    // memory responder: two cycles per access
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end else if (mem_req) begin
            mem_rdata = {m[(mem_addr[9:0] + 10'd3)], m[(mem_addr[9:0] + 10'd2)],
                         m[(mem_addr[9:0] + 10'd1)], m[mem_addr[9:0]]};
            mem_err   = (mem_addr == err_addr);
            if (mem_we && !mem_err) m[mem_addr[9:0]] = mem_wdata[7:0];
            mem_ack   = 1'b1;
        end
    end

    // device model
    always @(negedge clk) begin
        if (hs_pend) begin
            if (dev_idx < 64) rx[dev_idx] = cap;
            dev_idx = dev_idx + 1;
        end
        hs_pend    = 1'b0;
        din_valid  = dev_en && (dev_idx < dev_n);
        dout_ready = dev_en && (dev_idx < dev_n);
        din_data   = pat(2, dev_idx);
        dev_final  = (dev_idx == dev_n - 1);
        if ((din_valid && din_ready) || (dout_valid && dout_ready)) begin
            hs_pend = 1'b1;
            cap     = dout_data;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic put32(input logic [31:0] a, input logic [31:0] w);
        for (int b = 0; b < 4; b++) m[a[9:0] + 10'(b)] = w[8*b +: 8];
    endtask

    // map byte k of the transfer to a buffer address; 0 if past the table
    function automatic logic [31:0] loc(int nd, int k);
        int base = 0;
        for (int j = 0; j < nd; j++) begin
            if (k < base + dlen[j]) return buf_of(j) + 32'(k - base);
            base += dlen[j];
        end
        return 32'h0;
    endfunction

    task automatic run_case(input bit tomem, input int nd, input int ndev,
                            input logic [31:0] exp_st, input int exp_mv,
                            input string req);
        logic [31:0] v;
        logic [31:0] a;
        bit ok;
        for (int i = 12'h100; i < 1024; i++) m[i] = 8'hEE;
        for (int j = 0; j < nd; j++) begin
            put32(TBL + 32'(8 * j), buf_of(j));
            put32(TBL + 32'(8 * j) + 32'd4, dword[j]);
        end
        if (!tomem)
            for (int k = 0; k < 40; k++) begin
                a = loc(nd, k);
                if (a != 0) m[a[9:0]] = pat(1, k);
            end
        dev_n = ndev; dev_idx = 0; dev_en = 1'b1;
        wr(3'd4, TBL);
        wr(3'd0, tomem ? 32'h9 : 32'h1);
        for (int t = 0; t < 3000; t++) begin
            rd(3'd2, v);
            if ((v & 32'h5) != 32'h1) break;
        end
        repeat (10) @(negedge clk);
        rd(3'd2, v);
        chk(v == exp_st, req, "end status", int'(v), int'(exp_st));
        chk(irq == exp_st[2], "R9", "irq vs interrupt bit", int'(irq), int'(exp_st[2]));
        chk(dev_idx == exp_mv, req, "bytes moved", dev_idx, exp_mv);
        ok = 1'b1;
        for (int k = 0; k < exp_mv; k++) begin
            a = loc(nd, k);
            if (tomem) begin
                if (m[a[9:0]] != pat(2, k)) ok = 1'b0;
            end else if (rx[k] != pat(1, k)) ok = 1'b0;
        end
        chk(ok, tomem ? "R3" : "R3", tomem ? "buffer bytes from device" : "device bytes from buffer",
            int'(ok), 1);
        if (tomem) begin
            a = loc(nd, exp_mv);
            if (a != 0) chk(m[a[9:0]] == 8'hEE, "R7", "byte past stop untouched",
                            int'(m[a[9:0]]), 8'hEE);
        end
        wr(3'd0, 32'h0);
        if (exp_st == 32'h5) begin
            rd(3'd2, v);
            chk(v == 32'h4, "R8", "clear start after early finish", int'(v), 4);
        end
        wr(3'd2, 32'h6);
        rd(3'd2, v);
        chk(v == 32'h0 && !irq, "R9", "status after write-one-clear", int'(v), 0);
        dev_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] v;
        string tg;
        for (int i = 0; i < 1024; i++) m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        rd(3'd0, v); chk(v == 0, "R1", "control after reset", int'(v), 0);
        rd(3'd2, v); chk(v == 0, "R1", "status after reset", int'(v), 0);
        rd(3'd4, v); chk(v == 0, "R1", "base after reset", int'(v), 0);
        chk(!irq && !mem_req, "R1", "outputs idle after reset", int'(irq), 0);
        wr(3'd4, 32'h1237);
        rd(3'd4, v); chk(v == 32'h1234, "R1", "base low bits read zero", int'(v), 32'h1234);
        wr(3'd0, 32'h8);
        rd(3'd0, v); chk(v == 32'h8, "R1", "direction bit readback", int'(v), 8);
        wr(3'd0, 32'h0);

        // sweep: one entry of L bytes against a device of N bytes, both directions
        for (int dir = 0; dir < 2; dir++)
            for (int L = 1; L <= 6; L++)
                for (int N = 1; N <= 6; N++) begin
                    dlen[0]  = L;
                    dword[0] = 32'h8000_0000 | 32'(L);
                    if (N == L)      run_case(dir[0], 1, N, 32'h4, N, "R5");
                    else if (N < L)  run_case(dir[0], 1, N, 32'h5, N, "R6");
                    else             run_case(dir[0], 1, N, 32'h0, L, "R7");
                end

        // R2: scatter across three entries
        dlen[0] = 3; dlen[1] = 5; dlen[2] = 4;
        dword[0] = 32'd3; dword[1] = 32'd5; dword[2] = 32'h8000_0004;
        run_case(1'b1, 3, 12, 32'h4, 12, "R2");
        run_case(1'b0, 3, 12, 32'h4, 12, "R2");
        run_case(1'b1, 3, 5, 32'h5, 5, "R2");
        run_case(1'b0, 3, 15, 32'h0, 12, "R2");

        // R4: upper count bits ignored, zero count means 65536
        dlen[0] = 3; dword[0] = 32'h807F_0003;
        run_case(1'b1, 1, 3, 32'h4, 3, "R4");
        dlen[0] = 64; dword[0] = 32'h8000_0000;
        run_case(1'b1, 1, 5, 32'h5, 5, "R4");

        // R10: bus error on the count-word fetch
        err_addr = TBL + 32'd4;
        dlen[0] = 4; dword[0] = 32'h8000_0004;
        run_case(1'b1, 1, 4, 32'h2, 0, "R10");
        err_addr = 32'hFFFF_FFFF;

        // R8: abort while waiting for device data
        for (int i = 12'h100; i < 1024; i++) m[i] = 8'hEE;
        put32(TBL, buf_of(0)); put32(TBL + 32'd4, 32'h8000_0014);
        dev_n = 0; dev_idx = 0; dev_en = 1'b1;
        wr(3'd4, TBL);
        wr(3'd0, 32'h9);
        repeat (20) @(negedge clk);
        rd(3'd2, v); chk(v == 32'h1, "R8", "active while waiting", int'(v), 1);
        wr(3'd0, 32'h0);
        rd(3'd2, v); chk(v == 32'h0 && !irq, "R8", "abort clears active", int'(v), 0);
        repeat (10) @(negedge clk);
        chk(!mem_req && !din_ready, "R8", "no beat after abort", int'(mem_req), 0);
        chk(m[buf_of(0)] == 8'hEE, "R8", "buffer untouched", int'(m[buf_of(0)]), 8'hEE);
        dev_en = 1'b0;

        tg = "done";
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule